// File: doc/BRIEF.md
# Alternating-Code Watchdog Supervisor

This block is a supervisor watchdog for a small system. It has three byte-wide registers on a simple write/read port: a reset-cause log, a kick-code register and a period register. The watchdog stays idle until software writes the period register. That write loads a 7-bit timeout and a tick-source select bit and starts a down-counter. The counter then steps on either a slow 32 kHz tick or a tick derived from the system clock. If the system clock is reported as stopped, the counter pauses while the system-clock source is selected.

While the watchdog runs, software keeps it alive by writing kick codes. Only 0x5A and 0xC3 are accepted, and each accepted code must differ from the one accepted before it. Any accepted code reloads the counter. If the counter runs out, or a kick code is wrong, the block raises a reset request for a fixed number of cycles, records the cause, and returns to idle. Power-on and brownout arrive as single-cycle event inputs. They are logged in the same cause register, and they also stop the watchdog.

Register map: address 0 is the cause log, address 1 is the kick code, and address 2 is the period register. Address 3 reads as zero and ignores writes. Read data is combinational from the addressed register.

Top module: `wdog_supervisor`

## Requirements
- R1: After `rst_n` is deasserted, the watchdog is idle, `rst_req` is 0, the cause log (address 0) reads 0x00, and the period register (address 2) reads 0x00.
- R2: A write to address 2 while idle does three things. It stores `wdata[6:0]` as the timeout and `wdata[7]` as the tick select (0 = slow tick `lf_tick`, 1 = system tick `hf_tick`). It starts the watchdog. The stored value reads back at address 2 in the same bit positions.
- R3: While the watchdog is running, writes to address 2 are ignored. The readback of address 2 and the timing of the timeout are unchanged.
- R4: Every accepted kick write (address 1) reloads the counter with the stored timeout. A single accepted write is enough to delay the timeout by a full period.
- R5: With a stored timeout N ≥ 1 and no kick, the N-th selected tick after start or reload causes the timeout. A stored timeout of 0 behaves as 1. On a timeout, bit 1 of the cause log is set and `rst_req` rises one cycle after that tick.
- R6: A running kick write is a violation if its byte is neither 0x5A nor 0xC3, or if it equals the previously accepted code. A violation sets bit 2 of the cause log and raises `rst_req` one cycle after the write.
- R7: After each start, the first kick may be either 0x5A or 0xC3. The record of the previous code is cleared whenever the watchdog becomes idle.
- R8: With select = 1, the counter steps only on `hf_tick` cycles where `hf_run` is 1. With select = 0, it steps only on `lf_tick`. Ticks from the unselected source have no effect.
- R9: Cause flags are never cleared by the hardware. A write to address 0 clears exactly the flags whose `wdata` bit is 1. A 0 bit leaves its flag unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R10: The cause log layout is bit 0 power-on, bit 1 timeout, bit 2 code violation, bit 3 brownout, with bits 7:4 reading 0. A `por_evt` pulse sets bits 0 and 3. A `bo_evt` pulse sets bit 3 only. Either event makes the watchdog idle.
- R11: A watchdog event drives `rst_req` high for exactly RST_LEN cycles. An event during a pulse does not lengthen it. Afterwards the watchdog is idle, the counter is cleared, and the cause flags are kept.
- R12: Kick writes while the watchdog is idle are ignored. They raise no `rst_req` and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the block |
| por_evt | input | 1 | One-cycle power-on event |
| bo_evt | input | 1 | One-cycle brownout event |
| lf_tick | input | 1 | Slow 32 kHz tick strobe |
| hf_tick | input | 1 | Tick strobe derived from the system clock |
| hf_run | input | 1 | High while the system clock is running |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| rst_req | output | 1 | Reset request pulse |

## Verification
All state is registered on the rising edge, so every write or tick takes effect at the edge where it is presented. The next read returns the new state, and `rst_req` rises in the cycle after the offending write or tick. The bench drives inputs at the falling edge, holds them across one rising edge and samples at the following falling edge. It therefore counts each result one cycle after its cause, and the pulse length is measured by sampling `rst_req` on consecutive falling edges. Timeout checks confirm that `rst_req` is still low after N−1 ticks and high right after the N-th.

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int TMO_W   = 7,
  parameter int RST_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_evt,
  input  logic       bo_evt,
  input  logic       lf_tick,
  input  logic       hf_tick,
  input  logic       hf_run,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rst_req
);
  localparam int PW = $clog2(RST_LEN + 1);
  localparam logic [7:0] CODE_A = 8'h5A;
  localparam logic [7:0] CODE_B = 8'hC3;

  logic             en, sel, have_prev, prev_a;
  logic [TMO_W-1:0] period, cnt;
  logic [3:0]       cause;
  logic [PW-1:0]    pcnt;

  wire wr_cause = wr_en && addr == 2'd0;
  wire wr_code  = wr_en && addr == 2'd1 && en;
  wire wr_per   = wr_en && addr == 2'd2 && !en;

  wire is_a    = wdata == CODE_A;
  wire is_b    = wdata == CODE_B;
  wire repeatd = have_prev && (prev_a ? is_a : is_b);
  wire kick_ok = wr_code && (is_a || is_b) && !repeatd;
  wire kick_bad = wr_code && !kick_ok;

  wire tick   = en && (sel ? (hf_tick && hf_run) : lf_tick);
  wire expire = tick && !kick_ok && cnt <= 1;
  wire ext_evt = por_evt || bo_evt;
  wire wd_evt  = expire || kick_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      sel       <= 1'b0;
      period    <= '0;
      cnt       <= '0;
      have_prev <= 1'b0;
      prev_a    <= 1'b0;
    end else if (wd_evt || ext_evt) begin
      en        <= 1'b0;
      cnt       <= '0;
      have_prev <= 1'b0;
    end else if (wr_per) begin
      en        <= 1'b1;
      sel       <= wdata[7];
      period    <= wdata[TMO_W-1:0];
      cnt       <= wdata[TMO_W-1:0];
      have_prev <= 1'b0;
    end else if (kick_ok) begin
      cnt       <= period;
      have_prev <= 1'b1;
      prev_a    <= is_a;
    end else if (tick) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause <= '0;
    else begin
      cause <= (cause & ~(wr_cause ? wdata[3:0] : 4'b0))
             | {por_evt || bo_evt, kick_bad, expire, por_evt};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else if (wd_evt && pcnt == '0) pcnt <= PW'(RST_LEN);
    else if (pcnt != '0) pcnt <= pcnt - 1'b1;
  end

  assign rst_req = pcnt != '0;

  always_comb begin
    rdata = 8'h00;
    case (addr)
      2'd0: rdata = {4'b0000, cause};
      2'd2: rdata = {sel, period};
      default: rdata = 8'h00;
    endcase
  end
endmodule

module wdog_supervisor_chk #(
  parameter int TMO_W   = 7,
  parameter int RST_LEN = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_evt,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [7:0]       wdata,
  input logic             rst_req,
  input logic             en,
  input logic             sel,
  input logic [TMO_W-1:0] period,
  input logic [3:0]       cause
);
  logic [7:0] hl;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hl <= '0;
    else if (rst_req) hl <= hl + 1'b1;
    else hl <= '0;
  end

  a_r11_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> hl == 8'(RST_LEN));
  a_r11_idle_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> !en);
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ($stable(period) && $stable(sel)));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 2'd0) |=> ((cause & $past(cause)) == $past(cause)));
  a_r10_por_both: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> (cause[0] && cause[3]));
endmodule

bind wdog_supervisor wdog_supervisor_chk #(.TMO_W(TMO_W), .RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rst_req(rst_req), .en(en), .sel(sel), .period(period),
  .cause(cause)
);

// File: tb/tb_wdog_supervisor.sv
module tb_wdog_supervisor;
  localparam int RST_LEN = 4;
  logic clk = 0, rst_n = 0, por_evt = 0, bo_evt = 0, lf_tick = 0, hf_tick = 0, hf_run = 1;
  logic wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic rst_req;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  wdog_supervisor #(.TMO_W(7), .RST_LEN(RST_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .bo_evt(bo_evt),
    .lf_tick(lf_tick), .hf_tick(hf_tick), .hf_run(hf_run), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic lf(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lf_tick = 1; @(posedge clk); @(negedge clk); lf_tick = 0;
    end
  endtask

  task automatic hf(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); hf_tick = 1; @(posedge clk); @(negedge clk); hf_tick = 0;
    end
  endtask

  task automatic settle();
    logic [7:0] d;
    while (rst_req) @(negedge clk);
    wr(0, 8'h0F);
    rd(0, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 rst_req", {7'b0, rst_req}, 8'h00);
    rd(0, d); check("R1 cause", d, 8'h00);
    rd(2, d); check("R1 period", d, 8'h00);
  endtask

  task automatic t_idle_kick();
    logic [7:0] d;
    wr(1, 8'h11);
    check("R12 no req", {7'b0, rst_req}, 8'h00);
    rd(0, d); check("R12 no flag", d, 8'h00);
  endtask

  task automatic t_timeout();
    logic [7:0] d;
    wr(2, 8'h03);
    rd(2, d); check("R2 readback", d, 8'h03);
    wr(2, 8'h7F);
    rd(2, d); check("R3 frozen", d, 8'h03);
    lf(2); check("R5 early", {7'b0, rst_req}, 8'h00);
    lf(1); check("R5 due", {7'b0, rst_req}, 8'h01);
    rd(0, d); check("R5 flag", d, 8'h02);
    settle();
  endtask

  task automatic t_pulse();
    int n = 0;
    logic [7:0] d;
    wr(2, 8'h01);
    lf(1);
    while (rst_req && n < 20) begin n++; @(negedge clk); end
    check("R11 length", 8'(n), 8'(RST_LEN));
    wr(2, 8'h05);
    rd(2, d); check("R11 idle after", d, 8'h05);
    rd(0, d); check("R11 flag kept", d, 8'h02);
    lf(5); settle();
  endtask

  task automatic t_kick();
    logic [7:0] d;
    wr(2, 8'h03);
    lf(2); wr(1, 8'hC3);
    lf(2); wr(1, 8'h5A);
    lf(2); check("R4 reload", {7'b0, rst_req}, 8'h00);
    wr(1, 8'h5A);
    check("R6 repeat", {7'b0, rst_req}, 8'h01);
    rd(0, d); check("R6 flag", d, 8'h04);
    settle();
    wr(2, 8'h03);
    wr(1, 8'h5A);
    check("R7 either first", {7'b0, rst_req}, 8'h00);
    wr(1, 8'h11);
    check("R6 bad byte", {7'b0, rst_req}, 8'h01);
    settle();
    wr(2, 8'h03);
    wr(1, 8'h5A);
    check("R7 cleared", {7'b0, rst_req}, 8'h00);
    lf(3); settle();
  endtask

  task automatic t_hf();
    logic [7:0] d;
    wr(2, 8'h82);
    rd(2, d); check("R2 select", d, 8'h82);
    hf_run = 0; hf(4);
    lf(4);
    check("R8 suspended", {7'b0, rst_req}, 8'h00);
    hf_run = 1; hf(1);
    check("R8 one", {7'b0, rst_req}, 8'h00);
    hf(1);
    check("R8 due", {7'b0, rst_req}, 8'h01);
    settle();
  endtask

  task automatic t_events();
    logic [7:0] d;
    @(negedge clk); por_evt = 1; @(posedge clk); @(negedge clk); por_evt = 0;
    rd(0, d); check("R10 por", d, 8'h09);
    wr(0, 8'h01);
    rd(0, d); check("R9 clear one", d, 8'h08);
    wr(0, 8'h00);
    rd(0, d); check("R9 zero keeps", d, 8'h08);
    wr(0, 8'hF8);
    @(negedge clk); bo_evt = 1; @(posedge clk); @(negedge clk); bo_evt = 0;
    rd(0, d); check("R10 bo", d, 8'h08);
    wr(2, 8'h02);
    @(negedge clk); bo_evt = 1; @(posedge clk); @(negedge clk); bo_evt = 0;
    wr(1, 8'h11);
    check("R10 idle", {7'b0, rst_req}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle_kick();
    t_timeout();
    t_pulse();
    t_kick();
    t_hf();
    t_events();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule